// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block makes the hazard decisions for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. In each cycle it receives a description of the instruction in decode: whether the slot is valid, its two source register numbers and whether each one is actually read, its destination register, whether it writes that register, and whether it is a load. It also receives a taken-redirect flag that the execute stage resolves for a branch or jump. The block keeps a small record of what each later stage holds: the execute-stage sources, destination and load flag, and the destinations in the memory and writeback stages. From that record it produces all of its control outputs. The datapath, register file and ALU lie outside the block.

There are three kinds of output. The first is a write enable shared by the PC and the fetch/decode register, which drops when the pipeline must stall. The second is a bubble request and a pair of flush requests for the fetch/decode and decode/execute registers. The third is a pair of forwarding selects, one for each ALU operand of the instruction in execute. Every output is combinational and depends on the current decode inputs and the stage record. The caller therefore uses the outputs in the same cycle. The register file has two read ports and one write port, so reading two sources and writing one result in the same cycle never causes a stall.

The bubble that a stall or flush places in the decode/execute slot has the same encoding as `addi x0, x0, 0`. It has destination register 0 and its write flag is off, so it can never start a forward or a stall later on.

Top module: `hz_ctrl`

## Requirements
- R1: After synchronous reset the stage record is empty. With an idle decode input, `pc_ifid_we` is 1, `idex_bubble`, `ifid_flush` and `idex_flush` are 0, and both forwarding selects are 2'b00.
- R2: A load-use stall happens when the instruction in execute is a load that writes register rd, and the valid instruction in decode reads rd through an enabled source. In that cycle `pc_ifid_we` is 0 and `idex_bubble` is 1. The stall lasts exactly one cycle when decode is held.
- R3: No stall occurs when the execute-stage load's destination matches no source in decode, or when it matches only a source whose read-enable is 0.
- R4: An operand whose source register equals the destination of a register-writing instruction in the memory stage gets the select 2'b10, which means forward from EX/MEM.
- R5: An operand that matches only a writing instruction in the writeback stage gets 2'b01, which means forward from MEM/WB. An operand with no match gets 2'b00, which means use the register file.
- R6: When both later stages write the register an operand reads, the select is 2'b10. The newer result wins.
- R7: Register 0 never causes a forward or a stall, even when an older instruction names it as its destination.
- R8: When `ex_taken` is 1, `ifid_flush` and `idex_flush` are both 1 and `pc_ifid_we` is 1. The instruction in decode during that cycle never reaches execute.
- R9: When `ex_taken` is 0 both flush outputs stay 0, and the instruction after a branch that is not taken proceeds normally.
- R10: A flush takes priority over a load-use stall in the same cycle. In that case `idex_bubble` is 0, `pc_ifid_we` is 1, and both flushes are 1.
- R11: A slot emptied by a stall bubble or a flush writes no register, so it never causes a forward from any later stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | Decode source register for operand A |
| id_rs2 | input | 5 | Decode source register for operand B |
| id_use_rs1 | input | 1 | Operand A reads the register file |
| id_use_rs2 | input | 1 | Operand B reads the register file |
| id_rd | input | 5 | Decode destination register |
| id_reg_write | input | 1 | Decode instruction writes its destination |
| id_is_load | input | 1 | Decode instruction is a load |
| ex_taken | input | 1 | Branch or jump in execute was taken |
| pc_ifid_we | output | 1 | Write enable for the PC and the fetch/decode register |
| idex_bubble | output | 1 | Put a bubble into decode/execute (stall) |
| ifid_flush | output | 1 | Replace fetch/decode contents with a NOP |
| idex_flush | output | 1 | Replace decode/execute input with a NOP |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_b | output | 2 | Operand B select: 00 register file, 01 MEM/WB, 10 EX/MEM |

## Verification
The assertions check four things on every cycle. A stall never lasts two cycles in a row. A redirect always overrides a stall and leaves the PC write enabled. A killed slot enters execute empty, with no destination and no write. No forward or stall ever comes from register 0. Other behaviours can only be shown by the bench's instruction sequences. These include the exact forwarding code chosen for each dependency distance, the newer stage winning when both later stages match, and the held instruction forwarding from writeback after its stall. They also include the proof that a flushed instruction never reaches execute: the bench has a later reader look for its destination and finds no forward.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int unsigned REG_AW  = 5;
    parameter int unsigned NUM_SRC = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    // Source side of an instruction: which registers it reads.
    typedef struct packed {
        logic                         valid;
        logic [NUM_SRC-1:0]           use_src;
        reg_idx_t [NUM_SRC-1:0]       rs;
    } src_req_t;

    // Destination side of an instruction: which register it writes.
    typedef struct packed {
        logic     valid;
        logic     wr;
        reg_idx_t rd;
    } dst_tag_t;

    typedef enum logic [1:0] {
        FWD_REGFILE  = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_e;

    // A bubble matches addi x0, x0, 0: rd = 0 and no write.
    localparam src_req_t EMPTY_SRC = '0;
    localparam dst_tag_t EMPTY_DST = '0;

    // True when the tag writes register r, with register 0 excluded.
    function automatic logic writes_reg(dst_tag_t d, reg_idx_t r);
        return d.valid && d.wr && (d.rd != '0) && (d.rd == r);
    endfunction

endpackage

// File: rtl/hz_slot_pipe.sv
module hz_slot_pipe
    import hz_pkg::*;
#(
    parameter int unsigned LATE_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  src_req_t id_src,
    input  dst_tag_t id_dst,
    input  logic     id_ld,
    input  logic     kill_id,
    output src_req_t ex_src,
    output dst_tag_t ex_dst,
    output logic     ex_ld,
    output dst_tag_t mem_dst,
    output dst_tag_t wb_dst
);

    localparam int unsigned LAST = LATE_STAGES - 1;

    src_req_t ex_src_q;
    dst_tag_t ex_dst_q;
    logic     ex_ld_q;
    dst_tag_t late_q [LATE_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_src_q <= EMPTY_SRC;
            ex_dst_q <= EMPTY_DST;
            ex_ld_q  <= 1'b0;
            for (int i = 0; i < LATE_STAGES; i++) late_q[i] <= EMPTY_DST;
        end else begin
            if (kill_id) begin
                ex_src_q <= EMPTY_SRC;
                ex_dst_q <= EMPTY_DST;
                ex_ld_q  <= 1'b0;
            end else begin
                ex_src_q <= id_src;
                ex_dst_q <= id_dst;
                ex_ld_q  <= id_ld;
            end
            late_q[0] <= ex_dst_q;
            for (int i = 1; i < LATE_STAGES; i++) late_q[i] <= late_q[i-1];
        end
    end

    assign ex_src  = ex_src_q;
    assign ex_dst  = ex_dst_q;
    assign ex_ld   = ex_ld_q;
    assign mem_dst = late_q[0];
    assign wb_dst  = late_q[LAST];

    // R11: a killed slot enters execute as a non-writing bubble
    p_kill_silent_r11: assert property (@(posedge clk) disable iff (rst)
        kill_id |=> (!ex_dst.wr && ex_dst.rd == '0 && !ex_ld));

    // R8: the killed decode instruction never occupies execute
    p_kill_empties_ex_r8: assert property (@(posedge clk) disable iff (rst)
        kill_id |=> (!ex_src.valid && !ex_dst.valid));

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_req_t id_src,
    input  dst_tag_t ex_dst,
    input  logic     ex_ld,
    output logic     hit
);

    logic [NUM_SRC-1:0] src_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = id_src.valid && id_src.use_src[g] && ex_ld
                            && writes_reg(ex_dst, id_src.rs[g]);
    end

    assign hit = |src_hit;

    // R7: a load naming register 0 never holds the pipeline
    p_x0_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> (ex_dst.rd != '0));

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  src_req_t                 ex_src,
    input  dst_tag_t                 mem_dst,
    input  dst_tag_t                 wb_dst,
    output logic [NUM_SRC-1:0][1:0]  sel
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        logic reads;
        logic hit_mem;
        logic hit_wb;

        assign reads   = ex_src.valid && ex_src.use_src[g];
        assign hit_mem = reads && writes_reg(mem_dst, ex_src.rs[g]);
        assign hit_wb  = reads && writes_reg(wb_dst, ex_src.rs[g]);

        // Newer result (memory stage) wins over writeback.
        always_comb begin
            if (hit_mem)     sel[g] = FWD_FROM_MEM;
            else if (hit_wb) sel[g] = FWD_FROM_WB;
            else             sel[g] = FWD_REGFILE;
        end

        // R7: register 0 is never a forwarding source
        p_fwd_not_x0_r7: assert property (@(posedge clk) disable iff (rst)
            (sel[g] != FWD_REGFILE) |-> (ex_src.rs[g] != '0));
    end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       id_valid,
    input  logic [4:0] id_rs1,
    input  logic [4:0] id_rs2,
    input  logic       id_use_rs1,
    input  logic       id_use_rs2,
    input  logic [4:0] id_rd,
    input  logic       id_reg_write,
    input  logic       id_is_load,
    input  logic       ex_taken,
    output logic       pc_ifid_we,
    output logic       idex_bubble,
    output logic       ifid_flush,
    output logic       idex_flush,
    output logic [1:0] fwd_a,
    output logic [1:0] fwd_b
);

    src_req_t id_src;
    dst_tag_t id_dst;
    src_req_t ex_src;
    dst_tag_t ex_dst;
    logic     ex_ld;
    dst_tag_t mem_dst;
    dst_tag_t wb_dst;
    logic     lu_hit;
    logic     stall;
    logic     kill_id;
    logic [NUM_SRC-1:0][1:0] sel;

    always_comb begin
        id_src.valid      = id_valid;
        id_src.use_src[0] = id_use_rs1;
        id_src.use_src[1] = id_use_rs2;
        id_src.rs[0]      = id_rs1;
        id_src.rs[1]      = id_rs2;
        id_dst.valid      = id_valid;
        id_dst.wr         = id_reg_write;
        id_dst.rd         = id_rd;
    end

    // A redirect outranks a stall: the stalled instruction is on the wrong path.
    assign stall   = lu_hit && !ex_taken;
    assign kill_id = stall || ex_taken;

    assign pc_ifid_we  = !stall;
    assign idex_bubble = stall;
    assign ifid_flush  = ex_taken;
    assign idex_flush  = ex_taken;
    assign fwd_a       = sel[0];
    assign fwd_b       = sel[1];

    hz_slot_pipe #(.LATE_STAGES(2)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .id_src  (id_src),
        .id_dst  (id_dst),
        .id_ld   (id_valid && id_is_load),
        .kill_id (kill_id),
        .ex_src  (ex_src),
        .ex_dst  (ex_dst),
        .ex_ld   (ex_ld),
        .mem_dst (mem_dst),
        .wb_dst  (wb_dst)
    );

    hz_load_use u_lu (
        .clk    (clk),
        .rst    (rst),
        .id_src (id_src),
        .ex_dst (ex_dst),
        .ex_ld  (ex_ld),
        .hit    (lu_hit)
    );

    hz_fwd_pick u_fwd (
        .clk     (clk),
        .rst     (rst),
        .ex_src  (ex_src),
        .mem_dst (mem_dst),
        .wb_dst  (wb_dst),
        .sel     (sel)
    );

    // R2: a stall never repeats in the following cycle
    p_stall_once_r2: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> !idex_bubble);

    // R10: a redirect keeps the PC moving and suppresses the bubble
    p_flush_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ex_taken |-> (pc_ifid_we && !idex_bubble && ifid_flush && idex_flush));

endmodule

// File: tb/hz_ctrl_bench.sv
`timescale 1ns/1ps
module hz_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       id_valid = 1'b0;
    logic [4:0] id_rs1 = '0;
    logic [4:0] id_rs2 = '0;
    logic       id_use_rs1 = 1'b0;
    logic       id_use_rs2 = 1'b0;
    logic [4:0] id_rd = '0;
    logic       id_reg_write = 1'b0;
    logic       id_is_load = 1'b0;
    logic       ex_taken = 1'b0;
    logic       pc_ifid_we;
    logic       idex_bubble;
    logic       ifid_flush;
    logic       idex_flush;
    logic [1:0] fwd_a;
    logic [1:0] fwd_b;

    always #2.5 clk = ~clk;

    hz_ctrl u_hz_ctrl (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_rd(id_rd),
        .id_reg_write(id_reg_write), .id_is_load(id_is_load), .ex_taken(ex_taken),
        .pc_ifid_we(pc_ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush),
        .idex_flush(idex_flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // Expected vector: {we, bubble, ifid_flush, idex_flush, fwd_a, fwd_b}
    localparam logic [7:0] E_IDLE  = 8'b1_0_0_0_00_00;
    localparam logic [7:0] E_STALL = 8'b0_1_0_0_00_00;
    localparam logic [7:0] E_FLUSH = 8'b1_0_1_1_00_00;

    function automatic logic [7:0] e_fwd(input logic [1:0] a, input logic [1:0] b);
        return {4'b1000, a, b};
    endfunction

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;

    task automatic step(input logic v, input logic [4:0] rs1, input logic [4:0] rs2,
                        input logic u1, input logic u2, input logic [4:0] rd,
                        input logic wr, input logic ld, input logic tk,
                        input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        id_valid = v; id_rs1 = rs1; id_rs2 = rs2; id_use_rs1 = u1; id_use_rs2 = u2;
        id_rd = rd; id_reg_write = wr; id_is_load = ld; ex_taken = tk;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic nop(input logic [7:0] exp, input string tag);
        step(1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, exp, tag);
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) nop(E_IDLE, "drain");
    endtask

    // Monitor: compares one queued expectation per cycle, mid low phase.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = {pc_ifid_we, idex_bubble, ifid_flush, idex_flush, fwd_a, fwd_b};
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        nop(E_IDLE, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;
        nop(E_IDLE, "R1 idle after reset");

        // R4: distance-one dependency forwards from EX/MEM; R9 nothing flushed
        step(1, 0, 0, 0, 0, 5, 1, 0, 0, E_IDLE, "R9 producer");
        step(1, 5, 0, 1, 0, 10, 1, 0, 0, E_IDLE, "R9 consumer in decode");
        nop(e_fwd(2'b10, 2'b00), "R4 fwd_a from EX/MEM");
        nop(E_IDLE, "R4 no fwd after");
        drain();

        // R5: distance-two dependency on operand B forwards from MEM/WB
        step(1, 0, 0, 0, 0, 7, 1, 0, 0, E_IDLE, "R5 producer");
        nop(E_IDLE, "R5 gap");
        step(1, 0, 7, 0, 1, 0, 0, 0, 0, E_IDLE, "R5 consumer in decode");
        nop(e_fwd(2'b00, 2'b01), "R5 fwd_b from MEM/WB");
        drain();

        // R6: both later stages write r9, the newer wins on both operands
        step(1, 0, 0, 0, 0, 9, 1, 0, 0, E_IDLE, "R6 older");
        step(1, 0, 0, 0, 0, 9, 1, 0, 0, E_IDLE, "R6 newer");
        step(1, 9, 9, 1, 1, 0, 0, 0, 0, E_IDLE, "R6 consumer in decode");
        nop(e_fwd(2'b10, 2'b10), "R6 EX/MEM beats MEM/WB");
        drain();

        // R7: register 0 neither forwards nor stalls
        step(1, 0, 0, 0, 0, 0, 1, 0, 0, E_IDLE, "R7 writes x0");
        step(1, 0, 0, 1, 1, 0, 0, 0, 0, E_IDLE, "R7 reads x0");
        nop(E_IDLE, "R7 no fwd from x0");
        drain();
        step(1, 0, 0, 0, 0, 0, 1, 1, 0, E_IDLE, "R7 load to x0");
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, E_IDLE, "R7 no stall on x0");
        drain();

        // R2/R11: load-use stall, one cycle, bubble forwards nothing
        step(1, 0, 0, 0, 0, 4, 1, 1, 0, E_IDLE, "R2 load");
        step(1, 0, 4, 0, 1, 11, 1, 0, 0, E_STALL, "R2 load-use stall");
        step(1, 0, 4, 0, 1, 11, 1, 0, 0, E_IDLE, "R11 bubble in execute");
        nop(e_fwd(2'b00, 2'b01), "R2 held instr forwards from MEM/WB");
        drain();

        // R3: unrelated or disabled sources do not stall
        step(1, 0, 0, 0, 0, 4, 1, 1, 0, E_IDLE, "R3 load");
        step(1, 3, 5, 1, 1, 0, 0, 0, 0, E_IDLE, "R3 different regs");
        drain();
        step(1, 0, 0, 0, 0, 4, 1, 1, 0, E_IDLE, "R3 load");
        step(1, 4, 4, 0, 0, 0, 0, 0, 0, E_IDLE, "R3 disabled sources");
        drain();

        // R8: taken branch flushes; the flushed instruction never reaches execute
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, E_IDLE, "R8 branch");
        step(1, 0, 0, 0, 0, 6, 1, 0, 1, E_FLUSH, "R8 taken flush");
        nop(E_IDLE, "R8 flushed slot");
        step(1, 6, 0, 1, 0, 0, 0, 0, 0, E_IDLE, "R8 reader in decode");
        nop(E_IDLE, "R8 flushed instr never forwards");
        drain();

        // R9: not-taken branch, the next instruction proceeds
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, E_IDLE, "R9 branch");
        step(1, 0, 0, 0, 0, 12, 1, 0, 0, E_IDLE, "R9 not taken no flush");
        step(1, 12, 0, 1, 0, 0, 0, 0, 0, E_IDLE, "R9 reader");
        nop(e_fwd(2'b10, 2'b00), "R9 fall-through instr executed");
        drain();

        // R10: redirect and load-use in the same cycle, flush wins
        step(1, 0, 0, 0, 0, 8, 1, 1, 0, E_IDLE, "R10 load");
        step(1, 0, 8, 0, 1, 0, 0, 0, 1, E_FLUSH, "R10 flush beats stall");
        nop(E_IDLE, "R10 dependent discarded");
        drain();

        @(negedge clk);
        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule